// File: doc/BRIEF.md
# Timer Counter Clock Edge Selector

This block sits between a timer channel's chosen count source and its up-counter. It watches a count-source level that has already been synchronised to the system clock. Once per qualifying transition of that level, it emits a count-enable pulse one cycle wide. A 2-bit edge field in an 8-bit per-channel control register picks the qualifying transitions: low-to-high only, high-to-low only, or both. Counting on both edges doubles the count rate for a given source. The 16-bit counter that consumes the pulses is part of the block.

Two situations override the edge field.

- **Phase-counting mode on a capable channel.** On channels 1 and 2 this mode takes priority. The edge path then stays silent, because a separate quadrature path (not part of this block) drives the count.
- **Undivided or cascaded source.** When the source is the undivided system clock, or another channel's overflow/underflow, the field can still be written and read back. The counter then behaves as if the field held its reset value. For the undivided clock this means one count on every running cycle, since that source has no edge. For a cascaded source it means low-to-high transitions only.

Prescaled sources are assumed to be divide-by-4 or slower, so that their edges can be resolved.

A two-state machine tracks whether the counter is running:

- **States:** `ST_STOP` and `ST_COUNT`.
- **Transition "start":** `ST_STOP` to `ST_COUNT` when `run` is high at a clock edge.
- **Transition "halt":** `ST_COUNT` to `ST_STOP` when `run` is low at a clock edge.

The output decoder chooses one of five count modes: off, rise, fall, both, or every-cycle.

Top module: `tmr_edge_count`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, `count_val` reads 0 and `count_en` is low.
- R2: A write (`cfg_wr` high) at a clock edge where `run` is low stores all 8 bits of `cfg_wdata`. `cfg_rdata` shows the stored value from the following cycle on.
- R3: A write at a clock edge where `run` is high is ignored, and `cfg_rdata` keeps its previous value.
- R4: With edge field bits [4:3] = 00 and a prescaled source, `count_en` is high for exactly one cycle per 0-to-1 transition of the sampled `src_in`. That cycle is the one after the clock edge that samples the new level.
- R5: With bits [4:3] = 01 and a prescaled source, `count_en` pulses once per 1-to-0 transition of the sampled `src_in`.
- R6: With bits [4:3] = 10 or 11 and a prescaled source, `count_en` pulses on both transitions, giving twice the count of R4 for the same full source periods.
- R7: With `src_is_sysclk` high, `count_en` is high on every counting cycle whatever the edge field holds, and the field still reads back as written.
- R8: With `src_is_cascade` high (and `src_is_sysclk` low), only 0-to-1 transitions count, even when the field selects falling or both edges.
- R9: On a channel with `CHAN_ID` 1 or 2, `phase_mode` high holds `count_en` low, overriding R4 to R8. On any other channel, `phase_mode` has no effect.
- R10: `count_en` is high only while `run` is high and the state is `ST_COUNT`, that is, `run` was also high at the previous edge. `count_val` rises by one per `count_en` cycle and wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| src_in | input | 1 | Synchronised count-source level |
| src_is_sysclk | input | 1 | Source is the undivided system clock |
| src_is_cascade | input | 1 | Source is another channel's overflow/underflow |
| phase_mode | input | 1 | Phase-counting mode selected for this channel |
| run | input | 1 | Counter run bit |
| count_en | output | 1 | Single-cycle count-enable pulse |
| count_val | output | 16 | Counter value |

## Verification
The bench builds two copies side by side from the same stimulus. One is built with `CHAN_ID` = 1, where phase-counting mode overrides the edge path. The other is built with `CHAN_ID` = 0, where the same flag must be ignored. This brings the R9 override and its absence into one comparison. Both copies keep the default 16-bit counter width and 8-bit register width. The default counter width makes a wrap from 0xFFFF reachable with a run of about 65,540 cycles on the undivided-clock source.

// File: rtl/tmr_edge_pkg.sv
package tmr_edge_pkg;

    typedef enum logic {
        ST_STOP  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    typedef enum logic [2:0] {
        CM_OFF   = 3'd0,
        CM_RISE  = 3'd1,
        CM_FALL  = 3'd2,
        CM_BOTH  = 3'd3,
        CM_EVERY = 3'd4
    } cnt_mode_e;

    // Edge field: 00 rising, 01 falling, 1x both
    function automatic cnt_mode_e decode_edge(input logic [1:0] fld);
        cnt_mode_e m;
        if (fld[1])      m = CM_BOTH;
        else if (fld[0]) m = CM_FALL;
        else             m = CM_RISE;
        return m;
    endfunction

endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             run,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= '0;
        else if (wr && !run) q <= wdata;
    end

    // R2: a write while stopped lands in the register
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !run) |=> (q == $past(wdata)));

    // R3: a write while running leaves the register untouched
    p_write_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && run) |=> $stable(q));

endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic rise,
    output logic fall
);

    logic smp_q;
    logic prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            prv_q <= 1'b0;
        end else begin
            smp_q <= src;
            prv_q <= smp_q;
        end
    end

    assign rise = smp_q & ~prv_q;
    assign fall = ~smp_q & prv_q;

    // R4: a rising pulse never lasts two cycles
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5: a falling pulse never lasts two cycles
    p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R6: the two transitions are never reported together
    p_edges_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + ONE;
    end

    // R10: one step per enable, wrapping at the top
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + ONE));

    // R10: no step without an enable
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

endmodule

// File: rtl/tmr_edge_count.sv
module tmr_edge_count
    import tmr_edge_pkg::*;
#(
    parameter int CHAN_ID  = 1,
    parameter int REG_W    = 8,
    parameter int CNT_W    = 16,
    parameter int EDGE_LSB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             src_in,
    input  logic             src_is_sysclk,
    input  logic             src_is_cascade,
    input  logic             phase_mode,
    input  logic             run,
    output logic             count_en,
    output logic [CNT_W-1:0] count_val
);

    localparam bit PHASE_OK = (CHAN_ID == 1) || (CHAN_ID == 2);

    logic       rise;
    logic       fall;
    logic       phase_hold;
    run_state_e state_q;
    run_state_e state_d;
    cnt_mode_e  mode;

    tmr_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .run   (run),
        .wdata (cfg_wdata),
        .q     (cfg_rdata)
    );

    tmr_edge_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_in),
        .rise  (rise),
        .fall  (fall)
    );

    generate
        if (PHASE_OK) begin : g_phase
            assign phase_hold = phase_mode;
        end else begin : g_nophase
            assign phase_hold = 1'b0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Transitions: start (STOP->COUNT), halt (COUNT->STOP)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (run)  state_d = ST_COUNT;
            ST_COUNT: if (!run) state_d = ST_STOP;
            default:            state_d = ST_STOP;
        endcase
    end

    // Outputs: count mode and enable
    always_comb begin
        mode = CM_OFF;
        unique case (state_q)
            ST_STOP: mode = CM_OFF;
            ST_COUNT: begin
                if (!run || phase_hold) mode = CM_OFF;
                else if (src_is_sysclk) mode = CM_EVERY;
                else if (src_is_cascade) mode = CM_RISE;
                else mode = decode_edge(cfg_rdata[EDGE_LSB+1:EDGE_LSB]);
            end
            default: mode = CM_OFF;
        endcase
        unique case (mode)
            CM_RISE:  count_en = rise;
            CM_FALL:  count_en = fall;
            CM_BOTH:  count_en = rise | fall;
            CM_EVERY: count_en = 1'b1;
            default:  count_en = 1'b0;
        endcase
    end

    tmr_up_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (count_en),
        .cnt   (count_val)
    );

    // R10: no enable while the run bit is low
    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !count_en);

    // R9: phase-counting mode silences the edge path on capable channels
    p_phase_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (PHASE_OK && phase_mode) |-> !count_en);

    // R7: undivided clock counts on every running cycle
    p_every_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && src_is_sysclk && !phase_hold) |-> count_en);

    // R8: a cascaded source never counts a falling transition
    p_cascade_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_is_cascade && !src_is_sysclk && fall) |-> !count_en);

endmodule

// File: tb/tmr_edge_count_tb.sv
`timescale 1ns/1ps
module tmr_edge_count_tb;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        src_in = 1'b0;
    logic        src_is_sysclk = 1'b0;
    logic        src_is_cascade = 1'b0;
    logic        phase_mode = 1'b0;
    logic        run = 1'b0;

    logic [7:0]  rd1, rd0;
    logic        en1, en0;
    logic [15:0] cv1, cv0;

    int tests = 0;
    int fails = 0;

    always #(HALF) clk = ~clk;

    tmr_edge_count #(.CHAN_ID(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd1), .src_in(src_in), .src_is_sysclk(src_is_sysclk),
        .src_is_cascade(src_is_cascade), .phase_mode(phase_mode), .run(run),
        .count_en(en1), .count_val(cv1));

    tmr_edge_count #(.CHAN_ID(0)) u_dut0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd0), .src_in(src_in), .src_is_sysclk(src_is_sysclk),
        .src_is_cascade(src_is_cascade), .phase_mode(phase_mode), .run(run),
        .count_en(en0), .count_val(cv0));

    // ---------------- reference model ----------------
    bit         m_smp, m_prv, m_running;
    bit [7:0]   m_cfg;
    int         m_cnt1, m_cnt0;

    function automatic bit exp_en(input bit phase_capable);
        bit r, f;
        r = m_smp && !m_prv;
        f = !m_smp && m_prv;
        if (!m_running || !run) return 1'b0;
        if (phase_capable && phase_mode) return 1'b0;
        if (src_is_sysclk) return 1'b1;
        if (src_is_cascade) return r;
        if (m_cfg[4]) return r || f;
        if (m_cfg[3]) return f;
        return r;
    endfunction

    function automatic string tag_of(input bit phase_capable);
        if (!m_running || !run) return "R10";
        if (phase_capable && phase_mode) return "R9";
        if (src_is_sysclk) return "R7";
        if (src_is_cascade) return "R8";
        if (m_cfg[4]) return "R6";
        if (m_cfg[3]) return "R5";
        return "R4";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_smp <= 0; m_prv <= 0; m_running <= 0; m_cfg <= 0;
            m_cnt1 <= 0; m_cnt0 <= 0;
        end else begin
            if (exp_en(1'b1)) m_cnt1 <= (m_cnt1 + 1) % 65536;
            if (exp_en(1'b0)) m_cnt0 <= (m_cnt0 + 1) % 65536;
            m_smp <= src_in;
            m_prv <= m_smp;
            m_running <= run;
            if (cfg_wr && !run) m_cfg <= cfg_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk(tag_of(1'b1), int'(en1), int'(exp_en(1'b1)), "count_en ch1");
            chk(tag_of(1'b0), int'(en0), int'(exp_en(1'b0)), "count_en ch0");
            chk("R10", int'(cv1), m_cnt1, "count_val ch1");
            chk("R10", int'(cv0), m_cnt0, "count_val ch0");
            chk(run ? "R3" : "R2", int'(rd1), int'(m_cfg), "cfg_rdata ch1");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        cyc(1);
    endtask

    // Run a window with `periods` full source periods, optionally ending high
    task automatic window(input int periods, input bit end_high,
                          output int d1, output int d0);
        int b1, b0;
        cyc(1);
        #1;
        b1 = int'(cv1); b0 = int'(cv0);
        run = 1'b1;
        cyc(2);
        for (int p = 0; p < periods; p++) begin
            src_in = 1'b1; cyc(2);
            src_in = 1'b0; cyc(2);
        end
        if (end_high) begin
            src_in = 1'b1; cyc(2);
        end
        cyc(3);
        run = 1'b0;
        cyc(2);
        #1;
        d1 = (int'(cv1) - b1 + 65536) % 65536;
        d0 = (int'(cv0) - b0 + 65536) % 65536;
        src_in = 1'b0;
        cyc(3);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d1, d0, start;

        // R1: reset state
        cyc(2);
        #1;
        chk("R1", int'(rd1), 0, "cfg after reset");
        chk("R1", int'(cv1), 0, "count after reset");
        chk("R1", int'(en1), 0, "enable in reset");
        rst_n = 1'b1;
        cyc(2);
        #1;
        chk("R1", int'(cv1), 0, "count after release");

        // R2: write and read back while stopped
        wr_cfg(8'h5A);
        #1; chk("R2", int'(rd1), 8'h5A, "readback 0x5A");
        wr_cfg(8'hA5);
        #1; chk("R2", int'(rd1), 8'hA5, "readback 0xA5");

        // R4: rising edges, 4 periods -> 4; one extra rise -> 1
        wr_cfg(8'h00);
        window(4, 1'b0, d1, d0);
        chk("R4", d1, 4, "rising count 4 periods");
        window(0, 1'b1, d1, d0);
        chk("R4", d1, 1, "rising count single rise");

        // R5: falling edges, 4 periods -> 4; lone rise -> 0
        wr_cfg(8'h08);
        window(4, 1'b0, d1, d0);
        chk("R5", d1, 4, "falling count 4 periods");
        window(0, 1'b1, d1, d0);
        chk("R5", d1, 0, "falling count lone rise");

        // R6: both edges doubles the count (field 10 and 11)
        wr_cfg(8'h10);
        window(4, 1'b0, d1, d0);
        chk("R6", d1, 8, "both edges field 10");
        wr_cfg(8'hF8);
        window(3, 1'b0, d1, d0);
        chk("R6", d1, 6, "both edges field 11");

        // R3: write while running is ignored
        wr_cfg(8'h08);
        @(negedge clk); run = 1'b1;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'hFF;
        @(negedge clk); cfg_wr = 1'b0;
        cyc(1); #1;
        chk("R3", int'(rd1), 8'h08, "write during run");
        run = 1'b0;
        cyc(2);

        // R7: undivided clock counts every cycle, field irrelevant
        src_is_sysclk = 1'b1;
        #1; start = int'(cv1);
        run = 1'b1;
        cyc(11);
        run = 1'b0;
        cyc(1); #1;
        chk("R7", (int'(cv1) - start + 65536) % 65536, 10, "every-cycle count");
        chk("R7", int'(rd1), 8'h08, "field readback in sysclk mode");
        src_is_sysclk = 1'b0;
        cyc(2);

        // R8: cascade source counts rising even with falling selected
        src_is_cascade = 1'b1;
        window(0, 1'b1, d1, d0);
        chk("R8", d1, 1, "cascade lone rise with falling field");
        wr_cfg(8'h18);
        window(4, 1'b0, d1, d0);
        chk("R8", d1, 4, "cascade with both field");
        src_is_cascade = 1'b0;

        // R9: phase mode silences channel 1, not channel 0
        wr_cfg(8'h10);
        phase_mode = 1'b1;
        window(4, 1'b0, d1, d0);
        chk("R9", d1, 0, "phase mode channel 1");
        chk("R9", d0, 8, "phase mode ignored channel 0");
        phase_mode = 1'b0;

        // R10: no counting while stopped
        #1; start = int'(cv1);
        for (int k = 0; k < 4; k++) begin
            src_in = 1'b1; cyc(2);
            src_in = 1'b0; cyc(2);
        end
        #1;
        chk("R10", int'(cv1), start, "toggles while stopped");

        // R10: wrap past 0xFFFF
        src_is_sysclk = 1'b1;
        #1; start = int'(cv1);
        run = 1'b1;
        cyc(65541);
        run = 1'b0;
        cyc(1); #1;
        chk("R10", int'(cv1), (start + 65540) % 65536, "wrap value");
        src_is_sysclk = 1'b0;
        cyc(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule